// File: doc/BRIEF.md
# Reset Cause Controller

This block merges many separate reset requests into one active-high system reset, and keeps a record of which kinds of reset have happened. The requests are power-on, brown-out, an active-low external clear pin, a software reset command, a watchdog timeout, a configuration mismatch, a trap conflict, and three illegal-condition requests: an illegal opcode, a read of an uninitialised working register, and a security violation. Apart from the clear pin, every request arrives as a digital pulse that is synchronous to the clock.

The clear pin must pass a low-level filter before it counts as a request. The system reset is held for a fixed number of cycles after the last request has gone, so that the rest of the chip sees a reset of a known minimum length. The power-on request also resets the block itself, asynchronously.

The cause register is nine bits wide. Software can read it at any time and can overwrite it with a plain write strobe. A write never starts a reset. Cause bits survive every reset except power-on. Power-on leaves only the power-on and brown-out bits set.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Any sampled request from brown-out, software, watchdog, configuration mismatch, trap conflict, illegal opcode, uninitialised register, security violation or the filtered clear pin sets `sys_rst_o` high after that clock edge.
- R2: `sys_rst_o` stays high after the next 15 edges that sample no request, and falls after the 16th. A new request during that window restarts the count.
- R3: The clear pin is active low. A request is raised only after 4 consecutive edges have sampled it low, so the reset rises after the 5th such edge. A low pulse lasting 3 cycles or fewer causes no reset and leaves bit 7 at 0.
- R4: While `por_req_i` is high, `sys_rst_o` is high and the cause register reads 0x003, which is bit 0 (power-on) plus bit 1 (brown-out). This takes effect without waiting for a clock edge.
- R5: Each source sets its own bit at the edge that samples it: bit 1 brown-out, bit 2 illegal opcode or security violation, bit 3 uninitialised register, bit 4 software, bit 5 watchdog, bit 6 trap conflict, bit 7 clear pin, bit 8 configuration mismatch.
- R6: With no write and no request, the cause bits keep their value, including after a stretched reset ends. New causes are ORed into the bits already set.
- R7: When `cause_wen_i` is high, the register takes `cause_wdata_i` at the next edge, both setting and clearing bits. A write never raises `sys_rst_o`.
- R8: If a write and a hardware request hit the same bit in one cycle, the bit ends up set. All other bits take the write data.
- R9: An uninitialised-register request sets bit 3 only and leaves bit 2 unchanged.
- R10: `cause_rdata_o` always shows the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_req_i | input | 1 | Power-on request, active high, asynchronous |
| bor_req_i | input | 1 | Brown-out request |
| ext_clr_n_i | input | 1 | External clear pin, active low, filtered |
| sw_rst_req_i | input | 1 | Software reset command |
| wdt_req_i | input | 1 | Watchdog timeout |
| cfg_mismatch_req_i | input | 1 | Configuration mismatch |
| trap_conflict_req_i | input | 1 | Trap conflict |
| bad_opcode_req_i | input | 1 | Illegal opcode |
| uninit_reg_req_i | input | 1 | Uninitialised working register read |
| security_req_i | input | 1 | Security violation |
| cause_wen_i | input | 1 | Cause register write strobe |
| cause_wdata_i | input | 9 | Cause register write data |
| cause_rdata_o | output | 9 | Cause register read data |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
A table drives each request source alone with one-cycle pulses, and then a few combined sources. Each row shows whether the source lands in its own bit, and whether the illegal opcode and security requests share bit 2 while the uninitialised-register request stays apart in bit 3. Clear-pin pulses of 3 and 4 low cycles separate a rejected glitch from an accepted request, at the exact cycle where the reset rises. Further patterns cover a write racing a watchdog request, a second request arriving inside the stretch window, and accumulation across two resets. Together these separate hardware-wins priority, restart of the hold count and bit retention from a controller that clears its bits or ignores late requests.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int CAUSE_W = 9;

  localparam int POS_POR    = 0;
  localparam int POS_BOR    = 1;
  localparam int POS_ILL    = 2;
  localparam int POS_UNINIT = 3;
  localparam int POS_SW     = 4;
  localparam int POS_WDT    = 5;
  localparam int POS_TRAP   = 6;
  localparam int POS_EXT    = 7;
  localparam int POS_CFG    = 8;

  localparam logic [CAUSE_W-1:0] POR_VALUE = CAUSE_W'((1 << POS_POR) | (1 << POS_BOR));

  typedef struct packed {
    logic cfg_mismatch;
    logic trap_conflict;
    logic watchdog;
    logic sw_reset;
    logic security;
    logic uninit_reg;
    logic bad_opcode;
    logic brownout;
  } rst_src_t;

  function automatic logic [CAUSE_W-1:0] src_to_cause(input rst_src_t s, input logic ext);
    logic [CAUSE_W-1:0] v;
    v             = '0;
    v[POS_BOR]    = s.brownout;
    v[POS_ILL]    = s.bad_opcode | s.security;
    v[POS_UNINIT] = s.uninit_reg;
    v[POS_SW]     = s.sw_reset;
    v[POS_WDT]    = s.watchdog;
    v[POS_TRAP]   = s.trap_conflict;
    v[POS_EXT]    = ext;
    v[POS_CFG]    = s.cfg_mismatch;
    return v;
  endfunction
endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_n_i,
  output logic req_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_LEN);
  localparam logic [CW-1:0] CNT_HIT = CW'(FILT_LEN - 1);

  logic [CW-1:0] low_cnt;
  logic          filt_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      low_cnt <= '0;
      filt_q  <= 1'b0;
    end else if (pin_n_i) begin
      low_cnt <= '0;
      filt_q  <= 1'b0;
    end else begin
      if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
      filt_q <= (low_cnt >= CNT_HIT);
    end
  end

  assign req_o = filt_q;

  // R3: acceptance only after the full run of low samples
  assert_filter_len_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(req_o) |-> ($past(low_cnt) == CNT_HIT && !$past(pin_n_i)));
  assert_filter_drop_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    pin_n_i |=> !req_o);
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic sys_rst_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(HOLD);

  logic [CW-1:0] cnt;
  logic          rst_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      cnt   <= CNT_LOAD;
      rst_q <= 1'b1;
    end else if (req_i) begin
      cnt   <= CNT_LOAD;
      rst_q <= 1'b1;
    end else begin
      rst_q <= (cnt > CW'(1));
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign sys_rst_o = rst_q;

  // R1: a request raises the reset on the next cycle
  assert_req_raises_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    req_i |=> sys_rst_o);
  // R2: no early release while the hold count runs
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!req_i && cnt > CW'(1)) |=> sys_rst_o);
  assert_release_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sys_rst_o) |-> ($past(cnt) == CW'(1) && !$past(req_i)));
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
  import rstc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [CAUSE_W-1:0] hw_set_i,
  input  logic               wen_i,
  input  logic [CAUSE_W-1:0] wdata_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] base;

  always_comb base = wen_i ? wdata_i : cause_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) cause_q <= POR_VALUE;
    else       cause_q <= base | hw_set_i;
  end

  assign cause_o = cause_q;

  // R5 / R8: a hardware set always lands, write or not
  for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit_chk
    assert_hw_sets_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      hw_set_i[i] |=> cause_o[i]);
  end

  // R6: idle cycles keep the contents
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wen_i && hw_set_i == '0) |=> $stable(cause_o));
  // R7: a write alone is taken verbatim
  assert_write_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (wen_i && hw_set_i == '0) |=> (cause_o == $past(wdata_i)));
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rstc_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HOLD     = 16
) (
  input  logic               clk_i,
  input  logic               por_req_i,
  input  logic               bor_req_i,
  input  logic               ext_clr_n_i,
  input  logic               sw_rst_req_i,
  input  logic               wdt_req_i,
  input  logic               cfg_mismatch_req_i,
  input  logic               trap_conflict_req_i,
  input  logic               bad_opcode_req_i,
  input  logic               uninit_reg_req_i,
  input  logic               security_req_i,
  input  logic               cause_wen_i,
  input  logic [CAUSE_W-1:0] cause_wdata_i,
  output logic [CAUSE_W-1:0] cause_rdata_o,
  output logic               sys_rst_o
);
  rst_src_t           src;
  logic               ext_req;
  logic               any_req;
  logic [CAUSE_W-1:0] hw_set;

  always_comb begin
    src.brownout      = bor_req_i;
    src.bad_opcode    = bad_opcode_req_i;
    src.uninit_reg    = uninit_reg_req_i;
    src.security      = security_req_i;
    src.sw_reset      = sw_rst_req_i;
    src.watchdog      = wdt_req_i;
    src.trap_conflict = trap_conflict_req_i;
    src.cfg_mismatch  = cfg_mismatch_req_i;
  end

  assign any_req = (|src) | ext_req;
  assign hw_set  = src_to_cause(src, ext_req);

  rstc_pin_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk_i   (clk_i),
    .rst_i   (por_req_i),
    .pin_n_i (ext_clr_n_i),
    .req_o   (ext_req)
  );

  rstc_stretch #(.HOLD(HOLD)) u_stretch (
    .clk_i     (clk_i),
    .rst_i     (por_req_i),
    .req_i     (any_req),
    .sys_rst_o (sys_rst_o)
  );

  rstc_cause_reg u_cause (
    .clk_i    (clk_i),
    .rst_i    (por_req_i),
    .hw_set_i (hw_set),
    .wen_i    (cause_wen_i),
    .wdata_i  (cause_wdata_i),
    .cause_o  (cause_rdata_o)
  );

  // R7: a register write never starts a reset
  assert_write_no_reset_R7: assert property (@(posedge clk_i) disable iff (por_req_i)
    (cause_wen_i && !any_req && !sys_rst_o) |=> !sys_rst_o);
  // R9: uninitialised-register request keeps out of bit 2
  assert_uninit_apart_R9: assert property (@(posedge clk_i) disable iff (por_req_i)
    (uninit_reg_req_i && !bad_opcode_req_i && !security_req_i && !cause_wen_i)
      |=> $stable(cause_rdata_o[POS_ILL]));
endmodule

// File: tb/tb_rst_cause_ctrl.sv
`timescale 1ns/1ps
module tb_rst_cause_ctrl;
  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       pin_n = 1'b1;
  logic [7:0] src = '0;  // [7]cfg [6]trap [5]wdt [4]sw [3]security [2]uninit [1]opcode [0]bor
  logic       wen = 1'b0;
  logic [8:0] wdata = '0;
  logic [8:0] rdata;
  logic       sys_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rst_cause_ctrl dut (
    .clk_i               (clk),
    .por_req_i           (por),
    .bor_req_i           (src[0]),
    .ext_clr_n_i         (pin_n),
    .sw_rst_req_i        (src[4]),
    .wdt_req_i           (src[5]),
    .cfg_mismatch_req_i  (src[7]),
    .trap_conflict_req_i (src[6]),
    .bad_opcode_req_i    (src[1]),
    .uninit_reg_req_i    (src[2]),
    .security_req_i      (src[3]),
    .cause_wen_i         (wen),
    .cause_wdata_i       (wdata),
    .cause_rdata_o       (rdata),
    .sys_rst_o           (sys_rst)
  );

  localparam int NV = 10;
  localparam logic [7:0] VSRC [NV] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                                       8'h20, 8'h40, 8'h80, 8'h0A, 8'h30};
  localparam logic [8:0] VEXP [NV] = '{9'h002, 9'h004, 9'h008, 9'h004, 9'h010,
                                       9'h020, 9'h040, 9'h100, 9'h004, 9'h030};

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk) src = m;
    @(negedge clk) src = '0;
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge clk) begin wen = 1'b1; wdata = d; end
    @(negedge clk) wen = 1'b0;
  endtask

  task automatic hold_window(input string tag);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 15) check({tag, " still high at 15"}, 16'(sys_rst), 16'd1);
      if (k == 16) check({tag, " low at 16"}, 16'(sys_rst), 16'd0);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    // R4: power-on state
    repeat (3) @(negedge clk);
    check("R4 reset high during power-on", 16'(sys_rst), 16'd1);
    check("R4 cause after power-on", 16'(rdata), 16'h003);
    por = 1'b0;
    hold_window("R2 after power-on");
    check("R10 cause kept after power-on stretch", 16'(rdata), 16'h003);

    // R1 R5 R9: one row per source pattern
    for (int i = 0; i < NV; i++) begin
      wr(9'h000);
      pulse(VSRC[i]);
      check("R1 reset raised by source", 16'(sys_rst), 16'd1);
      check("R5 cause bit for source", 16'(rdata), 16'(VEXP[i]));
      hold_window("R2 source stretch");
    end

    // R3: short low pulse is ignored
    wr(9'h000);
    @(negedge clk) pin_n = 1'b0;
    repeat (3) @(negedge clk);
    pin_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 short pulse no reset", 16'(sys_rst), 16'd0);
    check("R3 short pulse no cause", 16'(rdata), 16'h000);

    // R3: four low samples accepted, reset on fifth edge
    @(negedge clk) pin_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 not yet at fourth edge", 16'(sys_rst), 16'd0);
    @(negedge clk);
    check("R3 reset at fifth edge", 16'(sys_rst), 16'd1);
    check("R3 clear pin bit 7", 16'(rdata), 16'h080);
    pin_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 released after pin high", 16'(sys_rst), 16'd0);

    // R7 R10: writes set and clear without reset
    wr(9'h1FF);
    check("R7 write all ones", 16'(rdata), 16'h1FF);
    check("R7 no reset from write", 16'(sys_rst), 16'd0);
    wr(9'h0A5);
    check("R7 write pattern", 16'(rdata), 16'h0A5);
    repeat (2) @(negedge clk);
    check("R7 still no reset", 16'(sys_rst), 16'd0);
    check("R10 read stable", 16'(rdata), 16'h0A5);

    // R6: persistence and accumulation
    wr(9'h000);
    pulse(8'h10);
    check("R6 software bit", 16'(rdata), 16'h010);
    repeat (20) @(negedge clk);
    check("R6 bit kept after reset ends", 16'(rdata), 16'h010);
    pulse(8'h20);
    check("R6 bits accumulate", 16'(rdata), 16'h030);
    repeat (20) @(negedge clk);

    // R8: write and hardware set collide
    wr(9'h1FF);
    @(negedge clk) begin wen = 1'b1; wdata = 9'h000; src = 8'h20; end
    @(negedge clk) begin wen = 1'b0; src = '0; end
    check("R8 hardware wins over write", 16'(rdata), 16'h020);
    repeat (20) @(negedge clk);

    // R2: retrigger inside the window
    pulse(8'h10);
    repeat (8) @(negedge clk);
    check("R2 high mid window", 16'(sys_rst), 16'd1);
    pulse(8'h20);
    hold_window("R2 retrigger");

    // R4: power-on wipes accumulated bits
    wr(9'h1F0);
    @(negedge clk) por = 1'b1;
    #1;
    check("R4 async cause on power-on", 16'(rdata), 16'h003);
    check("R4 async reset on power-on", 16'(sys_rst), 16'd1);
    @(negedge clk) por = 1'b0;
    hold_window("R2 second power-on");

    done = 1;
    finish_run();
  end
endmodule